// File: doc/BRIEF.md
# Addressable Output Latch Bank

This block holds eight single-bit outputs. A 3-bit address selects one of them, and a single data bit is written to that output. Two active-low control levels choose the mode. The first, `en_ni`, allows a write. The second, `clr_ni`, forces outputs to zero. Together they give four modes: write one bit, hold all bits, one-hot steer (demultiplex), and clear everything.

The bank is built from ordinary flip-flops on the system clock. Control levels, address and data are sampled at each rising edge, and the outputs take their new value one cycle later. A transparent write therefore appears here as the addressed bit following the data on every cycle the enable stays active. When the enable deasserts, the bit keeps the data sampled on the last enabled edge. The asynchronous reset clears the register to zero. A typical use is a set of individually addressed control strobes or flags fed from a narrow bus.

Top module: `sel_latch_bank`

## Requirements
- R1: While `rst_ni` is low, and on the first edge after it is released, `q_o` is 8'h00.
- R2: In steer mode with `data_i`=1, exactly one bit of `q_o` is set, and it is the bit at index `addr_i`.
- R3: In write mode (`en_ni`=0, `clr_ni`=1), `q_o[addr_i]` equals `data_i` after the edge.
- R4: In write mode, every bit other than `q_o[addr_i]` keeps its value across the edge.
- R5: In hold mode (`en_ni`=1, `clr_ni`=1), `q_o` does not change, whatever `addr_i` and `data_i` are.
- R6: In steer mode (`en_ni`=0, `clr_ni`=0), `q_o[addr_i]` equals `data_i` after the edge, and all other bits are 0.
- R7: In clear mode (`en_ni`=1, `clr_ni`=0), `q_o` becomes 8'h00 after the edge, whatever `addr_i` and `data_i` are.
- R8: If the address moves while writing, the bit selected earlier keeps the value it took on its last selected cycle.
- R9: When `en_ni` rises, the addressed bit holds the data sampled on the last edge at which `en_ni` was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, clears outputs |
| en_ni | input | 1 | Active-low write enable |
| clr_ni | input | 1 | Active-low clear |
| addr_i | input | 3 | Output select |
| data_i | input | 1 | Data for the selected output |
| q_o | output | 8 | Stored output bits |

## Verification
The hardest state to reach is a bank holding an irregular mix of ones and zeros when a hold, clear or steer cycle arrives. A mode that wrongly touches unselected bits, or wrongly leaves them alone, only shows up against such a pattern. The stimulus therefore walks a scrambled sequence through all 64 combinations of control, address and data, many times over. This leaves a varied pattern in the bank before each mode is entered. Directed sequences then cover the address moving during a write, and the enable rising while the data changes.

// File: rtl/sel_latch_pkg.sv
package sel_latch_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_STEER = 2'd2,
    MODE_CLEAR = 2'd3
  } mode_e;
endpackage

// File: rtl/sel_mode_dec.sv
module sel_mode_dec
  import sel_latch_pkg::*;
(
  input  logic  en_ni,
  input  logic  clr_ni,
  output mode_e mode_o
);
  always_comb begin
    unique case ({en_ni, clr_ni})
      2'b01:   mode_o = MODE_WRITE;
      2'b11:   mode_o = MODE_HOLD;
      2'b00:   mode_o = MODE_STEER;
      default: mode_o = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/sel_onehot_dec.sv
module sel_onehot_dec #(
  parameter int unsigned NUM_OUTS = 8,
  localparam int unsigned AW = $clog2(NUM_OUTS)
) (
  input  logic [AW-1:0]       addr_i,
  output logic [NUM_OUTS-1:0] sel_o
);
  for (genvar g = 0; g < NUM_OUTS; g++) begin : g_dec
    assign sel_o[g] = (addr_i == AW'(g));
  end

  always_comb begin
    if (!$isunknown(addr_i))
      assert_sel_onehot_R2: assert ($onehot(sel_o));
  end
endmodule

// File: rtl/sel_latch_cell.sv
module sel_latch_cell
  import sel_latch_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  logic  sel_i,
  input  logic  data_i,
  output logic  q_o
);
  logic q_d;

  always_comb begin
    unique case (mode_i)
      MODE_WRITE: q_d = sel_i ? data_i : q_o;
      MODE_HOLD:  q_d = q_o;
      MODE_STEER: q_d = sel_i & data_i;
      default:    q_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/sel_latch_bank.sv
module sel_latch_bank
  import sel_latch_pkg::*;
#(
  parameter int unsigned NUM_OUTS = 8,
  localparam int unsigned AW = $clog2(NUM_OUTS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_ni,
  input  logic                clr_ni,
  input  logic [AW-1:0]       addr_i,
  input  logic                data_i,
  output logic [NUM_OUTS-1:0] q_o
);
  mode_e               mode;
  logic [NUM_OUTS-1:0] sel;

  sel_mode_dec i_mode_dec (
    .en_ni  (en_ni),
    .clr_ni (clr_ni),
    .mode_o (mode)
  );

  sel_onehot_dec #(.NUM_OUTS(NUM_OUTS)) i_addr_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  for (genvar g = 0; g < NUM_OUTS; g++) begin : g_cell
    sel_latch_cell i_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (mode),
      .sel_i  (sel[g]),
      .data_i (data_i),
      .q_o    (q_o[g])
    );
  end

  assert_write_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_ni && clr_ni) |=> q_o[$past(addr_i)] == $past(data_i));

  assert_write_others_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_ni && clr_ni) |=> ((q_o & ~$past(sel)) == ($past(q_o) & ~$past(sel))));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_ni && clr_ni) |=> $stable(q_o));

  assert_steer_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_ni && !clr_ni) |=> ($countones(q_o) <= 1) && (q_o[$past(addr_i)] == $past(data_i)));

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_ni && !clr_ni) |=> (q_o == '0));
endmodule

// File: tb/test_sel_latch_bank.sv
module test_sel_latch_bank;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_ni = 1'b1;
  logic       clr_ni = 1'b1;
  logic [2:0] addr_i = '0;
  logic       data_i = 1'b0;
  logic [7:0] q_o;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_q = '0;

  always #4 clk_i = ~clk_i;

  sel_latch_bank i_sel_latch_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_ni  (en_ni),
    .clr_ni (clr_ni),
    .addr_i (addr_i),
    .data_i (data_i),
    .q_o    (q_o)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: q_o=%h expected=%h", req, act, exp);
    end
  endtask

  // apply one cycle at a negedge, model the result, check at the next negedge
  task automatic step(logic en, logic clr, logic [2:0] a, logic d);
    string req;
    en_ni = en; clr_ni = clr; addr_i = a; data_i = d;
    case ({en, clr})
      2'b01: begin exp_q[a] = d; req = "R3/R4 write"; end
      2'b11: req = "R5 hold";
      2'b00: begin exp_q = 8'(d) << a; req = "R6 steer"; end
      default: begin exp_q = '0; req = "R7 clear"; end
    endcase
    @(negedge clk_i);
    check(req, q_o, exp_q);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog: q_o=%h expected=done", q_o);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 in reset", q_o, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", q_o, 8'h00);

    // scrambled sweep over every control/address/data combination
    for (int i = 0; i < 1024; i++) begin
      logic [5:0] v;
      v = 6'((i * 37 + 11 + (i >> 6)) & 63);
      step(v[0], v[1], v[4:2], v[5]);
    end

    // R2: steer with data 1 gives exactly the addressed bit
    for (int a = 0; a < 8; a++) begin
      step(1'b0, 1'b0, 3'(a), 1'b1);
      check("R2 steer onehot", q_o, 8'h01 << a);
    end

    // R5: hold ignores address and data against a mixed pattern
    step(1'b1, 1'b0, 3'd0, 1'b0);
    for (int a = 0; a < 8; a += 2) step(1'b0, 1'b1, 3'(a), 1'b1);
    for (int v = 0; v < 16; v++) begin
      step(1'b1, 1'b1, 3'(v), v[3]);
      check("R5 hold pattern", q_o, 8'h55);
    end

    // R7: clear ignores address and data
    step(1'b1, 1'b0, 3'd3, 1'b1);
    check("R7 clear", q_o, 8'h00);

    // R8: address moves during write
    step(1'b0, 1'b1, 3'd2, 1'b1);
    step(1'b0, 1'b1, 3'd5, 1'b0);
    step(1'b0, 1'b1, 3'd5, 1'b1);
    check("R8 earlier bit kept", q_o, 8'h24);
    step(1'b0, 1'b1, 3'd2, 1'b0);
    check("R8 reselect", q_o, 8'h20);

    // R9: last enabled data is held once enable rises
    step(1'b0, 1'b1, 3'd7, 1'b0);
    step(1'b0, 1'b1, 3'd7, 1'b1);
    step(1'b1, 1'b1, 3'd7, 1'b0);
    check("R9 held data", q_o, 8'hA0);
    step(1'b1, 1'b1, 3'd7, 1'b0);
    check("R9 still held", q_o, 8'hA0);

    // R1: asynchronous reset mid-run
    #2 rst_ni = 1'b0;
    #1 check("R1 async clear", q_o, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    exp_q = '0;
    step(1'b1, 1'b1, 3'd1, 1'b1);
    check("R1 reset then hold", q_o, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule